// File: doc/BRIEF.md
# Burst Address Sequencer with Strobes

This block sits in front of a synchronous memory array and produces the address that the array uses each clock. A new base address is taken from the address bus when one of two active-low strobes is asserted: one strobe belongs to a processor and one to a controller. Three chip enables must all be active for the access to start. If a strobe is accepted while any enable is inactive, the cycle becomes a deselect.

After a start, the two low address bits feed a two-bit burst counter and the upper bits stay frozen. An active-low advance input steps the counter, and holding advance high suspends the burst. A static mode input picks the order of the four burst addresses: linear (start plus count, modulo 4) or interleaved (start XOR count). After four steps the sequence wraps back to its first address. A controller strobe during a burst restarts the sequence from a new base address.

The state is held in registers and the address output is derived from those registers. Every result therefore appears on the outputs one clock edge after the stimulus that caused it.

Top module: `burst_addr_seq`

## Requirements
- R1: When an accepted strobe occurs with all three enables active (pipe enable `ce_pipe_n` low, `ce_hi` high, `ce_lo_n` low), then after that clock edge `sel_valid` is 1 and `arr_addr` equals the address sampled at that edge.
- R2: On an edge with no accepted strobe, the address bus is not sampled: the upper bits of `arr_addr` keep their value whatever the bus does.
- R3: An accepted strobe with any of the three enables inactive makes `sel_valid` 0 after that edge.
- R4: The processor strobe is ignored while `ce_pipe_n` is high. With the controller strobe high, that edge leaves `arr_addr` and `sel_valid` unchanged. The processor strobe takes priority over the controller strobe when both are accepted.
- R5: With `mode_ilv` = 0 (linear), the low two bits of `arr_addr` after n advances are (start + n) mod 4, and bits above bit 1 stay equal to the base.
- R6: With `mode_ilv` = 1 (interleaved), the low two bits after n advances are start XOR (n mod 4).
- R7: An edge with `adv_n` high and no accepted strobe holds the burst position: `arr_addr` is unchanged.
- R8: After four advances, `arr_addr` returns to the base address.
- R9: A controller strobe during a burst loads a new base and restarts the count at zero.
- R10: Synchronous reset gives `sel_valid` = 0 and `arr_addr` = 0 after the edge.
- R11: Advance while deselected has no effect: `sel_valid` stays 0 and `arr_addr` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| mode_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| ce_pipe_n | input | 1 | Pipelining chip enable, active low |
| ce_hi | input | 1 | Depth-expansion enable, active high |
| ce_lo_n | input | 1 | Depth-expansion enable, active low |
| addr_in | input | ADDR_W | Address bus |
| arr_addr | output | ADDR_W | Current array address |
| sel_valid | output | 1 | 1 while an access is active, 0 when deselected |

## Verification
Strobe capture, deselect, advance and suspend each change a register at the edge where they are sampled. Their effect is therefore due on `arr_addr` and `sel_valid` exactly one edge later. The bench changes inputs on the falling edge and waits for one rising edge. It then reads the outputs 1 ns after that edge, so each check lands in the cycle where its result is due. Expected addresses are rebuilt in the bench from the base, the start offset and the count of advances it has issued.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int LOW_W = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_CTL  = 2'd2
  } src_e;

  // offset of a beat within the burst window
  function automatic logic [LOW_W-1:0] burst_offset(
    input logic [LOW_W-1:0] start,
    input logic [LOW_W-1:0] cnt,
    input logic             ilv
  );
    logic [LOW_W-1:0] r;
    if (ilv) r = start ^ cnt;
    else     r = start + cnt;
    return r;
  endfunction
endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb
  import bas_pkg::*;
(
  input  logic strobe_cpu_n,
  input  logic strobe_ctl_n,
  input  logic ce_pipe_n,
  input  logic ce_hi,
  input  logic ce_lo_n,
  output src_e src,
  output logic load,
  output logic start_acc,
  output logic deselect
);
  logic cpu_ok;
  logic ctl_ok;
  logic ce_ok;

  always_comb begin
    cpu_ok = !strobe_cpu_n && !ce_pipe_n;
    ctl_ok = !strobe_ctl_n;
    ce_ok  = !ce_pipe_n && ce_hi && !ce_lo_n;
    if (cpu_ok)      src = SRC_CPU;
    else if (ctl_ok) src = SRC_CTL;
    else             src = SRC_NONE;
    load      = (src != SRC_NONE);
    start_acc = load && ce_ok;
    deselect  = load && !ce_ok;
  end

  always_comb begin
    AST_START_DESEL_EXCL: assert ($onehot0({start_acc, deselect})); // R3
  end
endmodule

// File: rtl/bas_burst_ctr.sv
module bas_burst_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (step)    count <= count + ONE;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0)); // R9
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clear && !step) |=> $stable(count)); // R7
  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (!clear && step) |=> (count == $past(count) + ONE)); // R8
endmodule

// File: rtl/bas_base_reg.sv
module bas_base_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_acc,
  input  logic              deselect,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base  <= '0;
      valid <= 1'b0;
    end else if (start_acc) begin
      base  <= addr_in;
      valid <= 1'b1;
    end else if (deselect) begin
      valid <= 1'b0;
    end
  end

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
    !start_acc |=> $stable(base)); // R2
  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    deselect |=> !valid); // R3
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              mode_ilv,
  input  logic              ce_pipe_n,
  input  logic              ce_hi,
  input  logic              ce_lo_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              sel_valid
);
  localparam int HI_W = ADDR_W - LOW_W;

  src_e             src;
  logic             load;
  logic             start_acc;
  logic             deselect;
  logic             step;
  logic [LOW_W-1:0] count;
  logic [ADDR_W-1:0] base;
  logic [LOW_W-1:0] offset;

  bas_strobe_arb u_arb (
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .ce_pipe_n    (ce_pipe_n),
    .ce_hi        (ce_hi),
    .ce_lo_n      (ce_lo_n),
    .src          (src),
    .load         (load),
    .start_acc    (start_acc),
    .deselect     (deselect)
  );

  bas_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst       (rst),
    .start_acc (start_acc),
    .deselect  (deselect),
    .addr_in   (addr_in),
    .base      (base),
    .valid     (sel_valid)
  );

  assign step = sel_valid && !adv_n && !load;

  bas_burst_ctr #(.CNT_W(LOW_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .clear (load),
    .step  (step),
    .count (count)
  );

  assign offset   = burst_offset(base[LOW_W-1:0], count, mode_ilv);
  assign arr_addr = {base[ADDR_W-1:LOW_W], offset};

  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> (sel_valid && arr_addr == $past(addr_in))); // R1
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    !start_acc |=> (arr_addr[ADDR_W-1:LOW_W] == $past(arr_addr[ADDR_W-1:LOW_W]))); // R5
  AST_IDLE_DESEL: assert property (@(posedge clk) disable iff (rst)
    (!sel_valid && !load) |=> (!sel_valid && $stable(arr_addr))); // R11
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!sel_valid && arr_addr == '0)); // R10
  AST_CPU_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ce_pipe_n && strobe_ctl_n) |=> ($stable(arr_addr) || $past(step))); // R4
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1, mode_ilv = 1'b0;
  logic ce_pipe_n = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] arr_addr;
  logic sel_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .adv_n(adv_n), .mode_ilv(mode_ilv), .ce_pipe_n(ce_pipe_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .addr_in(addr_in), .arr_addr(arr_addr), .sel_valid(sel_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs, then sample just after the edge
  task automatic cyc(input logic cpu_n, input logic ctl_n, input logic a_n,
                     input logic pipe_n, input logic hi, input logic lo_n,
                     input logic [AW-1:0] a);
    @(negedge clk);
    strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n; adv_n = a_n;
    ce_pipe_n = pipe_n; ce_hi = hi; ce_lo_n = lo_n; addr_in = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int n, input logic ilv);
    logic [1:0] s;
    logic [1:0] o;
    s = b[1:0];
    o = ilv ? (s ^ 2'(n % 4)) : 2'((int'(s) + n) % 4);
    return {b[AW-1:2], o};
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    cyc(1, 1, 1, 0, 1, 0, 20'h5A5A5);
    chk("R10 valid", 32'(sel_valid), 0);
    chk("R10 addr", 32'(arr_addr), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_order(input logic ilv, input logic [AW-1:0] b);
    mode_ilv = ilv;
    cyc(0, 1, 1, 0, 1, 0, b);
    chk("R1 valid", 32'(sel_valid), 1);
    chk("R1 addr", 32'(arr_addr), 32'(b));
    for (int n = 1; n <= 4; n++) begin
      cyc(1, 1, 0, 0, 1, 0, ~b);
      chk(ilv ? "R6 interleaved" : "R5 linear", 32'(arr_addr), 32'(exp_addr(b, n, ilv)));
    end
    chk("R8 wrap", 32'(arr_addr), 32'(b));
  endtask

  task automatic t_suspend;
    logic [AW-1:0] b = 20'h3C0F1;
    mode_ilv = 1'b0;
    cyc(0, 1, 1, 0, 1, 0, b);
    cyc(1, 1, 0, 0, 1, 0, '0);
    cyc(1, 1, 1, 0, 1, 0, 20'hFFFFF);
    chk("R7 hold1", 32'(arr_addr), 32'(exp_addr(b, 1, 0)));
    cyc(1, 1, 1, 0, 1, 0, 20'h00000);
    chk("R7 hold2", 32'(arr_addr), 32'(exp_addr(b, 1, 0)));
    chk("R2 upper", 32'(arr_addr[AW-1:2]), 32'(b[AW-1:2]));
    cyc(1, 1, 0, 0, 1, 0, '0);
    chk("R7 resume", 32'(arr_addr), 32'(exp_addr(b, 2, 0)));
  endtask

  task automatic t_restart;
    logic [AW-1:0] b1 = 20'h11112;
    logic [AW-1:0] b2 = 20'h87653;
    mode_ilv = 1'b1;
    cyc(0, 1, 1, 0, 1, 0, b1);
    cyc(1, 1, 0, 0, 1, 0, '0);
    cyc(1, 0, 0, 0, 1, 0, b2);
    chk("R9 new base", 32'(arr_addr), 32'(b2));
    cyc(1, 1, 0, 0, 1, 0, '0);
    chk("R9 count restarted", 32'(arr_addr), 32'(exp_addr(b2, 1, 1)));
  endtask

  task automatic t_ignore;
    logic [AW-1:0] b = 20'h24680;
    mode_ilv = 1'b0;
    cyc(0, 1, 1, 0, 1, 0, b);
    cyc(0, 1, 1, 1, 1, 0, 20'h9999B);
    chk("R4 valid kept", 32'(sel_valid), 1);
    chk("R4 addr kept", 32'(arr_addr), 32'(b));
    // both strobes accepted: processor wins, same start
    cyc(0, 0, 1, 0, 1, 0, 20'h13579);
    chk("R4 priority", 32'(arr_addr), 32'h13579);
  endtask

  task automatic t_deselect;
    logic [AW-1:0] held;
    cyc(0, 1, 1, 0, 0, 0, 20'h0AAAA);
    chk("R3 ce_hi low", 32'(sel_valid), 0);
    cyc(0, 1, 1, 0, 1, 0, 20'h0BBBB);
    cyc(1, 0, 1, 0, 1, 1, 20'h0CCCC);
    chk("R3 ce_lo_n high", 32'(sel_valid), 0);
    cyc(1, 0, 1, 1, 1, 0, 20'h0DDDD);
    chk("R3 pipe high via ctl", 32'(sel_valid), 0);
    held = arr_addr;
    cyc(1, 1, 0, 0, 1, 0, 20'h0EEEE);
    cyc(1, 1, 0, 0, 1, 0, 20'h0FFFF);
    chk("R11 stays deselected", 32'(sel_valid), 0);
    chk("R11 addr unchanged", 32'(arr_addr), 32'(held));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order(1'b0, 20'hABCD6);
    t_order(1'b1, 20'h55551);
    t_order(1'b1, 20'h00003);
    t_suspend();
    t_restart();
    t_ignore();
    t_deselect();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule